// File: doc/BRIEF.md
# 4:2:2 Chroma Pair Packer and Expander

This block holds two independent streaming paths that move YCbCr video between full-resolution chroma (4:4:4) and horizontally shared chroma (4:2:2). The packing path receives one pixel per beat in raster order. It groups the pixels of each line two at a time, keeps both luma samples, and replaces the two chroma pairs with their truncated average. It sends one packed 4:2:2 word per pair. The expanding path receives those packed words and emits two 4:4:4 pixels per word, each carrying the shared chroma.

Both paths use valid/ready handshakes with frame-start (user) and line-end (last) flags. Each path honours backpressure without losing or changing data. The byte order inside the packed word is chosen at elaboration by a parameter: luma-first or chroma-first. The packer feeds a frame buffer or link that carries the lower data rate. The expander sits at the front of a display or processing stage that needs every pixel to carry complete chroma.

Top module: `chroma422_codec`

## Requirements
- R1: Each packed word carries the even pixel's luma as Y0 and the odd pixel's luma as Y1, both unchanged.
- R2: The packed Cb is floor((Cb_even + Cb_odd) / 2), and the packed Cr is floor((Cr_even + Cr_odd) / 2). The sum is formed one bit wider, so 255 + 255 gives 255.
- R3: With ORDER = ORD_YUYV (default), the packed word holds Y0 in [7:0], Cb in [15:8], Y1 in [23:16] and Cr in [31:24]. With ORDER = ORD_UYVY, it holds Cb in [7:0], Y0 in [15:8], Cr in [23:16] and Y1 in [31:24]. The low byte is sent first.
- R4: A 4:4:4 pixel word carries Y in bits [23:16], Cb in [15:8] and Cr in [7:0].
- R5: A packed word's user flag equals the user flag of its even pixel. Its last flag equals the last flag of the pixel that closes the pair.
- R6: Pairing restarts after every input pixel with last set, so each line starts on an even pixel. A line of odd width pairs its final pixel with itself: Y1 = Y0, and the chroma equals that pixel's own chroma.
- R7: While the packer output is valid and not accepted, its data, user and last stay unchanged. No input pixel is lost or duplicated under any pattern of output stalls.
- R8: For each packed word, the expander emits two pixels in order: first {Y0, Cb, Cr}, then {Y1, Cb, Cr}.
- R9: Of the two expanded pixels, the first carries the word's user flag and never has last set. The second never has user set and carries the word's last flag.
- R10: The expander holds its output stable while stalled. It deasserts its input ready in the cycle after it accepts a word, and keeps it low until the second pixel has been loaded.
- R11: While reset is held, both output valids are low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pk_s_valid | input | 1 | Packer input pixel valid |
| pk_s_ready | output | 1 | Packer can accept a pixel |
| pk_s_data | input | 3*COMP_W | 4:4:4 pixel {Y, Cb, Cr} |
| pk_s_user | input | 1 | Frame start, on the first pixel of a frame |
| pk_s_last | input | 1 | Last pixel of a line |
| pk_m_valid | output | 1 | Packed word valid |
| pk_m_ready | input | 1 | Downstream accepts the packed word |
| pk_m_data | output | 4*COMP_W | Packed 4:2:2 pair |
| pk_m_user | output | 1 | Frame start of the packed word |
| pk_m_last | output | 1 | Packed word closes a line |
| ex_s_valid | input | 1 | Expander input word valid |
| ex_s_ready | output | 1 | Expander can accept a word |
| ex_s_data | input | 4*COMP_W | Packed 4:2:2 pair |
| ex_s_user | input | 1 | Frame start of the word |
| ex_s_last | input | 1 | Word closes a line |
| ex_m_valid | output | 1 | Expanded pixel valid |
| ex_m_ready | input | 1 | Downstream accepts the pixel |
| ex_m_data | output | 3*COMP_W | 4:4:4 pixel {Y, Cb, Cr} |
| ex_m_user | output | 1 | Frame start on the first expanded pixel |
| ex_m_last | output | 1 | Line end on the second expanded pixel |

## Verification
The assertions assume that input sources follow the handshake. A source keeps valid and its payload fixed until ready is seen, and it sets user only on the first pixel or word of a frame. The bench drivers hold each item until they observe ready and only then move on. The drivers raise user only at frame starts. The downstream readies are toggled pseudo-randomly, so the hold and no-loss properties are exercised under stalls of varying length, including lines of odd width.

// File: rtl/chroma422_pkg.sv
package chroma422_pkg;

   // Byte order of the packed 4:2:2 word (byte 0 in the low bits)
   typedef enum logic {
      ORD_YUYV = 1'b0,
      ORD_UYVY = 1'b1
   } byte_order_e;

   typedef enum logic {
      PK_EVEN = 1'b0,
      PK_ODD  = 1'b1
   } pack_phase_e;

   typedef enum logic {
      EX_FIRST  = 1'b0,
      EX_SECOND = 1'b1
   } expand_phase_e;

endpackage

// File: rtl/c422_chroma_avg.sv
module c422_chroma_avg #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] avg
);
   localparam int SUM_W = W + 1;

   logic [SUM_W-1:0] sum;

   always_comb begin
      sum = {1'b0, a} + {1'b0, b};
      avg = sum[SUM_W-1:1];
   end
endmodule

// File: rtl/c422_pair_packer.sv
module c422_pair_packer #(
   parameter int                          COMP_W = 8,
   parameter chroma422_pkg::byte_order_e  ORDER  = chroma422_pkg::ORD_YUYV
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                s_valid,
   output logic                s_ready,
   input  logic [3*COMP_W-1:0] s_data,
   input  logic                s_user,
   input  logic                s_last,
   output logic                m_valid,
   input  logic                m_ready,
   output logic [4*COMP_W-1:0] m_data,
   output logic                m_user,
   output logic                m_last
);
   import chroma422_pkg::*;

   localparam int PIX_W = 3 * COMP_W;
   localparam int PK_W  = 4 * COMP_W;
   localparam int N_CH  = 2;

   pack_phase_e      phase;
   logic [PIX_W-1:0] hold_pix;
   logic             hold_user;

   logic             out_free;
   logic             accept;
   logic             close_pair;
   logic [PIX_W-1:0] even_pix;
   logic             pair_user;
   logic [COMP_W-1:0] y_even, y_odd;
   logic [COMP_W-1:0] chroma_avg [N_CH];
   logic [PK_W-1:0]   packed_word;

   assign out_free   = !m_valid || m_ready;
   assign s_ready    = out_free;
   assign accept     = s_valid && s_ready;
   assign close_pair = accept && ((phase == PK_ODD) || s_last);

   // Self-pairing: in the even phase a closing pixel is its own partner
   assign even_pix  = (phase == PK_ODD) ? hold_pix  : s_data;
   assign pair_user = (phase == PK_ODD) ? hold_user : s_user;
   assign y_even    = even_pix[PIX_W-1 -: COMP_W];
   assign y_odd     = s_data[PIX_W-1 -: COMP_W];

   // Index 0 is Cr (low component), index 1 is Cb
   for (genvar g = 0; g < N_CH; g++) begin : g_chroma
      c422_chroma_avg #(.W(COMP_W)) u_avg (
         .a   (even_pix[g*COMP_W +: COMP_W]),
         .b   (s_data[g*COMP_W +: COMP_W]),
         .avg (chroma_avg[g])
      );
   end

   if (ORDER == ORD_UYVY) begin : g_uyvy
      assign packed_word = {y_odd, chroma_avg[0], y_even, chroma_avg[1]};
   end else begin : g_yuyv
      assign packed_word = {chroma_avg[0], y_odd, chroma_avg[1], y_even};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PK_EVEN;
         hold_pix  <= '0;
         hold_user <= 1'b0;
         m_valid   <= 1'b0;
         m_data    <= '0;
         m_user    <= 1'b0;
         m_last    <= 1'b0;
      end else begin
         if (close_pair) begin
            m_valid <= 1'b1;
            m_data  <= packed_word;
            m_user  <= pair_user;
            m_last  <= s_last;
         end else if (m_ready) begin
            m_valid <= 1'b0;
         end

         if (accept) begin
            if ((phase == PK_EVEN) && !s_last) begin
               hold_pix  <= s_data;
               hold_user <= s_user;
               phase     <= PK_ODD;
            end else begin
               phase <= PK_EVEN;
            end
         end
      end
   end
endmodule

// File: rtl/c422_pair_expander.sv
module c422_pair_expander #(
   parameter int                          COMP_W = 8,
   parameter chroma422_pkg::byte_order_e  ORDER  = chroma422_pkg::ORD_YUYV
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                s_valid,
   output logic                s_ready,
   input  logic [4*COMP_W-1:0] s_data,
   input  logic                s_user,
   input  logic                s_last,
   output logic                m_valid,
   input  logic                m_ready,
   output logic [3*COMP_W-1:0] m_data,
   output logic                m_user,
   output logic                m_last
);
   import chroma422_pkg::*;

   expand_phase_e     phase;
   logic [COMP_W-1:0] in_y0, in_y1, in_cb, in_cr;
   logic [COMP_W-1:0] hold_y1, hold_cb, hold_cr;
   logic              hold_last;
   logic              out_free;
   logic              accept;

   if (ORDER == ORD_UYVY) begin : g_uyvy
      assign in_cb = s_data[0*COMP_W +: COMP_W];
      assign in_y0 = s_data[1*COMP_W +: COMP_W];
      assign in_cr = s_data[2*COMP_W +: COMP_W];
      assign in_y1 = s_data[3*COMP_W +: COMP_W];
   end else begin : g_yuyv
      assign in_y0 = s_data[0*COMP_W +: COMP_W];
      assign in_cb = s_data[1*COMP_W +: COMP_W];
      assign in_y1 = s_data[2*COMP_W +: COMP_W];
      assign in_cr = s_data[3*COMP_W +: COMP_W];
   end

   assign out_free = !m_valid || m_ready;
   assign s_ready  = (phase == EX_FIRST) && out_free;
   assign accept   = s_valid && s_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= EX_FIRST;
         hold_y1   <= '0;
         hold_cb   <= '0;
         hold_cr   <= '0;
         hold_last <= 1'b0;
         m_valid   <= 1'b0;
         m_data    <= '0;
         m_user    <= 1'b0;
         m_last    <= 1'b0;
      end else if (accept) begin
         m_valid   <= 1'b1;
         m_data    <= {in_y0, in_cb, in_cr};
         m_user    <= s_user;
         m_last    <= 1'b0;
         hold_y1   <= in_y1;
         hold_cb   <= in_cb;
         hold_cr   <= in_cr;
         hold_last <= s_last;
         phase     <= EX_SECOND;
      end else if ((phase == EX_SECOND) && out_free) begin
         m_valid <= 1'b1;
         m_data  <= {hold_y1, hold_cb, hold_cr};
         m_user  <= 1'b0;
         m_last  <= hold_last;
         phase   <= EX_FIRST;
      end else if (m_ready) begin
         m_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/chroma422_codec.sv
module chroma422_codec #(
   parameter int                          COMP_W = 8,
   parameter chroma422_pkg::byte_order_e  ORDER  = chroma422_pkg::ORD_YUYV
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pk_s_valid,
   output logic                pk_s_ready,
   input  logic [3*COMP_W-1:0] pk_s_data,
   input  logic                pk_s_user,
   input  logic                pk_s_last,
   output logic                pk_m_valid,
   input  logic                pk_m_ready,
   output logic [4*COMP_W-1:0] pk_m_data,
   output logic                pk_m_user,
   output logic                pk_m_last,
   input  logic                ex_s_valid,
   output logic                ex_s_ready,
   input  logic [4*COMP_W-1:0] ex_s_data,
   input  logic                ex_s_user,
   input  logic                ex_s_last,
   output logic                ex_m_valid,
   input  logic                ex_m_ready,
   output logic [3*COMP_W-1:0] ex_m_data,
   output logic                ex_m_user,
   output logic                ex_m_last
);
   if (COMP_W < 2) begin : g_bad_width
      $error("chroma422_codec: COMP_W must be at least 2");
   end

   c422_pair_packer #(.COMP_W(COMP_W), .ORDER(ORDER)) u_packer (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_valid (pk_s_valid),
      .s_ready (pk_s_ready),
      .s_data  (pk_s_data),
      .s_user  (pk_s_user),
      .s_last  (pk_s_last),
      .m_valid (pk_m_valid),
      .m_ready (pk_m_ready),
      .m_data  (pk_m_data),
      .m_user  (pk_m_user),
      .m_last  (pk_m_last)
   );

   c422_pair_expander #(.COMP_W(COMP_W), .ORDER(ORDER)) u_expander (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_valid (ex_s_valid),
      .s_ready (ex_s_ready),
      .s_data  (ex_s_data),
      .s_user  (ex_s_user),
      .s_last  (ex_s_last),
      .m_valid (ex_m_valid),
      .m_ready (ex_m_ready),
      .m_data  (ex_m_data),
      .m_user  (ex_m_user),
      .m_last  (ex_m_last)
   );
endmodule

// File: rtl/chroma422_codec_chk.sv
module chroma422_codec_chk #(
   parameter int COMP_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                pk_s_valid,
   input logic                pk_s_ready,
   input logic                pk_s_last,
   input logic                pk_m_valid,
   input logic                pk_m_ready,
   input logic [4*COMP_W-1:0] pk_m_data,
   input logic                pk_m_user,
   input logic                pk_m_last,
   input logic                ex_s_valid,
   input logic                ex_s_ready,
   input logic                ex_m_valid,
   input logic                ex_m_ready,
   input logic [3*COMP_W-1:0] ex_m_data,
   input logic                ex_m_user,
   input logic                ex_m_last
);
   // R7: a stalled packed word does not change
   assert_pk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pk_m_valid && !pk_m_ready |=> pk_m_valid && $stable(pk_m_data)
                                    && $stable(pk_m_user) && $stable(pk_m_last));

   // R6: an accepted line-end pixel always closes a pair at once
   assert_pk_lineend_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pk_s_valid && pk_s_ready && pk_s_last |=> pk_m_valid && pk_m_last);

   // R10: a stalled expanded pixel does not change
   assert_ex_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ex_m_valid && !ex_m_ready |=> ex_m_valid && $stable(ex_m_data)
                                    && $stable(ex_m_user) && $stable(ex_m_last));

   // R9, R10: accepting a word yields a first pixel without last, input closed
   assert_ex_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ex_s_valid && ex_s_ready |=> ex_m_valid && !ex_m_last && !ex_s_ready);

   // R9: the pixel after a frame-start pixel never carries frame start
   assert_ex_user_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ex_m_valid && ex_m_ready && ex_m_user |=> !ex_m_user);
endmodule

bind chroma422_codec chroma422_codec_chk #(.COMP_W(COMP_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pk_s_valid (pk_s_valid),
   .pk_s_ready (pk_s_ready),
   .pk_s_last  (pk_s_last),
   .pk_m_valid (pk_m_valid),
   .pk_m_ready (pk_m_ready),
   .pk_m_data  (pk_m_data),
   .pk_m_user  (pk_m_user),
   .pk_m_last  (pk_m_last),
   .ex_s_valid (ex_s_valid),
   .ex_s_ready (ex_s_ready),
   .ex_m_valid (ex_m_valid),
   .ex_m_ready (ex_m_ready),
   .ex_m_data  (ex_m_data),
   .ex_m_user  (ex_m_user),
   .ex_m_last  (ex_m_last)
);

// File: tb/sim_chroma422_codec.sv
module sim_chroma422_codec;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [7:0] y0, y1, cb, cr;
      logic       user, last;
   } pair_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;

   logic        pk_s_valid = 1'b0, pk_s_user = 1'b0, pk_s_last = 1'b0;
   logic [23:0] pk_s_data = '0;
   logic        pk_m_ready = 1'b1;
   logic        pk_s_ready, pk_m_valid, pk_m_user, pk_m_last;
   logic [31:0] pk_m_data;

   logic        ex_s_valid = 1'b0, ex_s_user = 1'b0, ex_s_last = 1'b0;
   logic [31:0] ex_s_data = '0;
   logic        ex_m_ready = 1'b1;
   logic        ex_s_ready, ex_m_valid, ex_m_user, ex_m_last;
   logic [23:0] ex_m_data;

   // second instance: chroma-first order, packer path only
   logic        u1_pk_s_ready, u1_pk_m_valid, u1_pk_m_user, u1_pk_m_last;
   logic [31:0] u1_pk_m_data;
   logic        u1_ex_s_ready, u1_ex_m_valid, u1_ex_m_user, u1_ex_m_last;
   logic [23:0] u1_ex_m_data;

   int checks = 0;
   int fails  = 0;
   bit stall  = 1'b0;

   pair_t       pk_q[$];
   logic [25:0] ex_q[$];

   bit          have_even = 1'b0;
   logic [23:0] even_pix;
   logic        even_user;

   always #(CLK_PERIOD/2) clk = ~clk;

   chroma422_codec u0 (
      .clk(clk), .rst_n(rst_n),
      .pk_s_valid(pk_s_valid), .pk_s_ready(pk_s_ready), .pk_s_data(pk_s_data),
      .pk_s_user(pk_s_user), .pk_s_last(pk_s_last),
      .pk_m_valid(pk_m_valid), .pk_m_ready(pk_m_ready), .pk_m_data(pk_m_data),
      .pk_m_user(pk_m_user), .pk_m_last(pk_m_last),
      .ex_s_valid(ex_s_valid), .ex_s_ready(ex_s_ready), .ex_s_data(ex_s_data),
      .ex_s_user(ex_s_user), .ex_s_last(ex_s_last),
      .ex_m_valid(ex_m_valid), .ex_m_ready(ex_m_ready), .ex_m_data(ex_m_data),
      .ex_m_user(ex_m_user), .ex_m_last(ex_m_last)
   );

   chroma422_codec #(.ORDER(chroma422_pkg::ORD_UYVY)) u1 (
      .clk(clk), .rst_n(rst_n),
      .pk_s_valid(pk_s_valid), .pk_s_ready(u1_pk_s_ready), .pk_s_data(pk_s_data),
      .pk_s_user(pk_s_user), .pk_s_last(pk_s_last),
      .pk_m_valid(u1_pk_m_valid), .pk_m_ready(pk_m_ready), .pk_m_data(u1_pk_m_data),
      .pk_m_user(u1_pk_m_user), .pk_m_last(u1_pk_m_last),
      .ex_s_valid(1'b0), .ex_s_ready(u1_ex_s_ready), .ex_s_data(32'h0),
      .ex_s_user(1'b0), .ex_s_last(1'b0),
      .ex_m_valid(u1_ex_m_valid), .ex_m_ready(1'b1), .ex_m_data(u1_ex_m_data),
      .ex_m_user(u1_ex_m_user), .ex_m_last(u1_ex_m_last)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   function automatic logic [7:0] avg8(input logic [7:0] a, input logic [7:0] b);
      logic [8:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[8:1];
   endfunction

   // Packer driver with the reference model from R1, R2, R5, R6
   task automatic pk_pixel(input logic [23:0] p, input logic u, input logic l);
      pair_t e;
      pk_s_data  = p;
      pk_s_user  = u;
      pk_s_last  = l;
      pk_s_valid = 1'b1;
      forever begin
         @(negedge clk);
         if (pk_s_ready) break;
      end
      if (!have_even && l) begin
         e = '{y0: p[23:16], y1: p[23:16], cb: p[15:8], cr: p[7:0], user: u, last: 1'b1};
         pk_q.push_back(e);
      end else if (!have_even) begin
         have_even = 1'b1;
         even_pix  = p;
         even_user = u;
      end else begin
         e = '{y0: even_pix[23:16], y1: p[23:16], cb: avg8(even_pix[15:8], p[15:8]),
               cr: avg8(even_pix[7:0], p[7:0]), user: even_user, last: l};
         pk_q.push_back(e);
         have_even = 1'b0;
      end
      @(posedge clk);
      #1;
      pk_s_valid = 1'b0;
   endtask

   task automatic pk_line(input int n, input bit frame_start);
      for (int i = 0; i < n; i++)
         pk_pixel(24'($urandom), frame_start && (i == 0), i == n - 1);
   endtask

   // Expander driver, word in luma-first order (R3)
   task automatic ex_word(input logic [7:0] y0, input logic [7:0] y1,
                          input logic [7:0] cb, input logic [7:0] cr,
                          input logic u, input logic l);
      ex_s_data  = {cr, y1, cb, y0};
      ex_s_user  = u;
      ex_s_last  = l;
      ex_s_valid = 1'b1;
      forever begin
         @(negedge clk);
         if (ex_s_ready) break;
      end
      ex_q.push_back({u, 1'b0, y0, cb, cr});
      ex_q.push_back({1'b0, l, y1, cb, cr});
      @(posedge clk);
      #1;
      ex_s_valid = 1'b0;
   endtask

   // Downstream ready generation
   initial forever begin
      @(posedge clk);
      #1;
      pk_m_ready = stall ? 1'($urandom) : 1'b1;
      ex_m_ready = stall ? 1'($urandom) : 1'b1;
   end

   // Monitor / scoreboard
   logic        pk_was_stalled = 1'b0, ex_was_stalled = 1'b0, ex_took = 1'b0;
   logic [33:0] pk_prev;
   logic [25:0] ex_prev;
   initial forever begin
      @(negedge clk);
      if (rst_n) begin
         if (pk_was_stalled)
            check(pk_m_valid && {pk_m_data, pk_m_user, pk_m_last} == pk_prev,
                  "R7 packer hold", 64'({pk_m_valid, pk_m_data, pk_m_user, pk_m_last}),
                  64'({1'b1, pk_prev}));
         if (ex_was_stalled)
            check(ex_m_valid && {ex_m_user, ex_m_last, ex_m_data} == ex_prev,
                  "R10 expander hold", 64'({ex_m_valid, ex_m_user, ex_m_last, ex_m_data}),
                  64'({1'b1, ex_prev}));
         if (ex_took)
            check(!ex_s_ready, "R10 ready low after accept", 64'(ex_s_ready), 64'(0));

         if (pk_m_valid && pk_m_ready) begin
            if (pk_q.size() == 0) begin
               check(1'b0, "R7 unexpected packed word", 64'(pk_m_data), 64'(0));
            end else begin
               pair_t e;
               e = pk_q.pop_front();
               check({pk_m_data, pk_m_user, pk_m_last} == {e.cr, e.y1, e.cb, e.y0, e.user, e.last},
                     "R1 R2 R3 R4 R5 R6 packed word",
                     64'({pk_m_data, pk_m_user, pk_m_last}),
                     64'({e.cr, e.y1, e.cb, e.y0, e.user, e.last}));
               check(u1_pk_m_valid && u1_pk_m_data == {e.y1, e.cr, e.y0, e.cb},
                     "R3 chroma-first order", 64'(u1_pk_m_data),
                     64'({e.y1, e.cr, e.y0, e.cb}));
            end
         end
         if (ex_m_valid && ex_m_ready) begin
            if (ex_q.size() == 0) begin
               check(1'b0, "R8 unexpected pixel", 64'(ex_m_data), 64'(0));
            end else begin
               logic [25:0] x;
               x = ex_q.pop_front();
               check({ex_m_user, ex_m_last, ex_m_data} == x, "R4 R8 R9 expanded pixel",
                     64'({ex_m_user, ex_m_last, ex_m_data}), 64'(x));
            end
         end
      end
      pk_was_stalled = rst_n && pk_m_valid && !pk_m_ready;
      pk_prev        = {pk_m_data, pk_m_user, pk_m_last};
      ex_was_stalled = rst_n && ex_m_valid && !ex_m_ready;
      ex_prev        = {ex_m_user, ex_m_last, ex_m_data};
      ex_took        = rst_n && ex_s_valid && ex_s_ready;
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog expired", 64'(0), 64'(1));
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!pk_m_valid && !ex_m_valid && pk_s_ready && ex_s_ready,
            "R11 reset state", 64'({pk_m_valid, ex_m_valid, pk_s_ready, ex_s_ready}),
            64'(4'b0011));
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;

      // R1 R2 R5: four-pixel frame-start line, truncation and full-scale chroma
      pk_pixel(24'h0A64FF, 1'b1, 1'b0);
      pk_pixel(24'h1465FE, 1'b0, 1'b0);
      pk_pixel(24'h1EFF00, 1'b0, 1'b0);
      pk_pixel(24'h28FF01, 1'b0, 1'b1);
      // R6: three-pixel line, last pixel paired with itself
      pk_pixel(24'h320709, 1'b0, 1'b0);
      pk_pixel(24'h3C080A, 1'b0, 1'b0);
      pk_pixel(24'h46C8C9, 1'b0, 1'b1);
      // R6: pairing restarts on the next line
      pk_line(6, 1'b0);
      pk_line(1, 1'b0);

      // R8 R9: expander, plain words
      ex_word(8'h10, 8'h20, 8'h80, 8'h40, 1'b1, 1'b0);
      ex_word(8'hFF, 8'h00, 8'h01, 8'hFE, 1'b0, 1'b1);

      // R7 R10: random traffic with downstream stalls
      stall = 1'b1;
      for (int f = 0; f < 2; f++)
         for (int ln = 0; ln < 4; ln++)
            pk_line($urandom_range(5, 9), ln == 0);
      for (int i = 0; i < 40; i++)
         ex_word(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                 i == 0, (i % 5) == 4);
      repeat (20) @(posedge clk);
      stall = 1'b0;
      repeat (20) @(posedge clk);

      check(pk_q.size() == 0, "R7 all packed words delivered", 64'(pk_q.size()), 64'(0));
      check(ex_q.size() == 0, "R10 all pixels delivered", 64'(ex_q.size()), 64'(0));
      finish_run();
   end
endmodule